// File: doc/BRIEF.md
# Four-Lane Pipelined Multiply-Accumulate Filter

This block is the arithmetic core for small image kernels, such as a four-pixel bilinear blend. Four lanes run in parallel. Each lane multiplies a signed 10-bit sample by a signed 11-bit weight. The four products are added together. The sum then either replaces or is added to a 25-bit running total. A 16-bit slice of that total is placed on a registered output, which can be rounded and can be frozen.

Each lane has its own sample and weight registers, and each register has its own load enable. A weight can therefore be loaded once and kept for as many cycles as needed, so no separate weight store is required. A new operand set can enter on every clock. Results appear a fixed number of cycles later. The output pins can be released to high impedance at any time, independently of the clock.

Top module: `mac4_filter`

## Requirements
- R1: While `rst_ni` is low, every pipeline register clears. After reset, `res_o` reads 0 until the first operand set reaches the output.
- R2: An operand set sampled on rising edge N sets `res_o` after rising edge N+4, so the path has five register stages. A new set is accepted on every edge.
- R3: The pipeline forms the sum of the four lane products `smp_i[k]*cof_i[k]`, with both operands taken as signed two's complement. The most negative codes (-512 and -1024) are included. When `frac_i` is 0 (integer format), `res_o` is bits [15:0] of the 25-bit total.
- R4: If `acc_i` is 0, the total is loaded with the new product sum. If `acc_i` is 1, the product sum is added to the current total. The total wraps modulo 2^25.
- R5: When `smp_en_i[k]` is 0, the sample register of lane k keeps its old value. When `cof_en_i[k]` is 0, the weight register of lane k keeps its old value. Held values keep taking part in every later product.
- R6: When `frac_i` is 1 (fractional format), `res_o` is bits [21:6] of the total. This drops the duplicate sign bit of the products and keeps the 16 most significant bits of the four-product sum.
- R7: When `rnd_i` is 1 in fractional format, 32 is added to the total (modulo 2^25) before bits [21:6] are taken. In integer format, `rnd_i` has no effect.
- R8: If `out_upd_i` is 0, the output register keeps its value, while the total keeps updating. The enable is aligned with its own operand set.
- R9: `oe_ni` acts without a clock. When it is 1, `res_o` is high impedance. When it is 0, `res_o` shows the output register again at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; every register samples on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smp_i | input | 4x10 | Signed sample for each lane |
| cof_i | input | 4x11 | Signed weight for each lane |
| smp_en_i | input | 4 | Load enable for each lane's sample register |
| cof_en_i | input | 4 | Load enable for each lane's weight register |
| acc_i | input | 1 | 1 adds the sum to the total, 0 loads the total |
| frac_i | input | 1 | 1 selects fractional format, 0 selects integer format |
| rnd_i | input | 1 | Round the fractional output slice |
| out_upd_i | input | 1 | Output register update enable |
| oe_ni | input | 1 | Asynchronous active-low output drive enable |
| res_o | output | 16 | Three-state result word |

## Verification
Two things can change in the same cycle: the output register can be frozen while the running total is still accumulating, and the format or rounding selection can change at that same time. The stimulus randomises update enable, accumulate, format and rounding on every cycle. A behavioural model then decides, five edges later, whether the word seen on the pins is the held value or the newly rounded slice. The output-drive control is also toggled between clock edges in the same cycles. The bench checks that the pins let go and then return to the expected word before the next edge.

// File: rtl/mac4_pkg.sv
package mac4_pkg;

    // Control bits that travel down the pipe next to their operand set.
    typedef struct packed {
        logic acc;   // add to the total instead of loading it
        logic frac;  // fractional output slice
        logic rnd;   // rounding bias on the fractional slice
        logic upd;   // output register update enable
    } mac4_ctl_t;

endpackage

// File: rtl/mac4_lane.sv
module mac4_lane #(
    parameter int DW = 10,
    parameter int CW = 11,
    localparam int PW = DW + CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [DW-1:0] smp_i,
    input  logic [CW-1:0] cof_i,
    input  logic          smp_en_i,
    input  logic          cof_en_i,
    output logic [PW-1:0] prod_o
);

    typedef struct packed {
        logic [DW-1:0] smp;
        logic [CW-1:0] cof;
        logic [PW-1:0] prod;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic signed [PW-1:0] smp_x, cof_x;

    always_comb begin
        st_d = st_q;
        if (smp_en_i) st_d.smp = smp_i;
        if (cof_en_i) st_d.cof = cof_i;
        smp_x = PW'($signed(st_q.smp));
        cof_x = PW'($signed(st_q.cof));
        st_d.prod = smp_x * cof_x;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign prod_o = st_q.prod;

endmodule

// File: rtl/mac4_tree.sv
module mac4_tree
    import mac4_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PW    = 21,
    localparam int SW   = PW + $clog2(LANES)
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [LANES-1:0][PW-1:0]  prod_i,
    input  mac4_ctl_t                 ctl_i,
    output logic [SW-1:0]             sum_o,
    output mac4_ctl_t                 ctl_o
);

    // c1 is aligned with the input registers, c2 with the products and c3 with the sum.
    typedef struct packed {
        mac4_ctl_t     c1;
        mac4_ctl_t     c2;
        mac4_ctl_t     c3;
        logic [SW-1:0] sum;
    } tree_st_t;

    tree_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.c1 = ctl_i;
        st_d.c2 = st_q.c1;
        st_d.c3 = st_q.c2;
        st_d.sum = '0;
        for (int k = 0; k < LANES; k++) begin
            st_d.sum = st_d.sum + {{(SW-PW){prod_i[k][PW-1]}}, prod_i[k]};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sum_o = st_q.sum;
    assign ctl_o = st_q.c3;

endmodule

// File: rtl/mac4_accout.sv
module mac4_accout
    import mac4_pkg::*;
#(
    parameter int SW       = 23,
    parameter int AW       = 25,
    parameter int OW       = 16,
    parameter int FRAC_LSB = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [SW-1:0] sum_i,
    input  mac4_ctl_t     ctl_i,
    output logic [AW-1:0] acc_o,
    output logic [OW-1:0] out_o
);

    localparam logic [AW-1:0] HALF = AW'(1) << (FRAC_LSB - 1);

    typedef struct packed {
        logic [AW-1:0] acc;
        mac4_ctl_t     c4;
        logic [OW-1:0] out;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [AW-1:0] sum_x;
    logic [AW-1:0] biased;

    always_comb begin
        st_d  = st_q;
        sum_x = {{(AW-SW){sum_i[SW-1]}}, sum_i};
        st_d.acc = ctl_i.acc ? (st_q.acc + sum_x) : sum_x;
        st_d.c4  = ctl_i;
        biased   = st_q.acc + (st_q.c4.rnd ? HALF : '0);
        if (st_q.c4.upd) begin
            st_d.out = st_q.c4.frac ? biased[FRAC_LSB +: OW] : st_q.acc[OW-1:0];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign acc_o = st_q.acc;
    assign out_o = st_q.out;

endmodule

// File: rtl/mac4_filter.sv
module mac4_filter
    import mac4_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int DW       = 10,
    parameter int CW       = 11,
    parameter int AW       = 25,
    parameter int OW       = 16,
    parameter int FRAC_LSB = 6
) (
    input  logic                      clk_i,
    input  logic                      rst_ni,
    input  logic [LANES-1:0][DW-1:0]  smp_i,
    input  logic [LANES-1:0][CW-1:0]  cof_i,
    input  logic [LANES-1:0]          smp_en_i,
    input  logic [LANES-1:0]          cof_en_i,
    input  logic                      acc_i,
    input  logic                      frac_i,
    input  logic                      rnd_i,
    input  logic                      out_upd_i,
    input  logic                      oe_ni,
    output logic [OW-1:0]             res_o
);

    localparam int PW = DW + CW;
    localparam int SW = PW + $clog2(LANES);

    logic [LANES-1:0][PW-1:0] prod_w;
    logic [SW-1:0]            sum_w;
    logic [AW-1:0]            acc_w;
    logic [OW-1:0]            out_w;
    mac4_ctl_t                ctl_in_w, ctl_sum_w;

    assign ctl_in_w = '{acc: acc_i, frac: frac_i, rnd: rnd_i, upd: out_upd_i};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        mac4_lane #(.DW(DW), .CW(CW)) lane_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .smp_i    (smp_i[g]),
            .cof_i    (cof_i[g]),
            .smp_en_i (smp_en_i[g]),
            .cof_en_i (cof_en_i[g]),
            .prod_o   (prod_w[g])
        );
    end

    mac4_tree #(.LANES(LANES), .PW(PW)) tree_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .prod_i (prod_w),
        .ctl_i  (ctl_in_w),
        .sum_o  (sum_w),
        .ctl_o  (ctl_sum_w)
    );

    mac4_accout #(.SW(SW), .AW(AW), .OW(OW), .FRAC_LSB(FRAC_LSB)) accout_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sum_i  (sum_w),
        .ctl_i  (ctl_sum_w),
        .acc_o  (acc_w),
        .out_o  (out_w)
    );

    assign res_o = oe_ni ? {OW{1'bz}} : out_w;

endmodule

// File: rtl/mac4_filter_chk.sv
module mac4_filter_chk #(
    parameter int SW       = 23,
    parameter int AW       = 25,
    parameter int OW       = 16,
    parameter int FRAC_LSB = 6
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          acc_i,
    input logic          frac_i,
    input logic          rnd_i,
    input logic          out_upd_i,
    input logic          oe_ni,
    input logic [OW-1:0] res_o,
    input logic [SW-1:0] sum_w,
    input logic [AW-1:0] acc_w,
    input logic [OW-1:0] out_w
);

    localparam logic [AW-1:0] BIAS = AW'(1) << (FRAC_LSB - 1);

    logic [3:0] since_rst_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 since_rst_q <= '0;
        else if (since_rst_q < 4'd8) since_rst_q <= since_rst_q + 4'd1;
    end

    function automatic logic [AW-1:0] widen(logic [SW-1:0] s);
        return {{(AW-SW){s[SW-1]}}, s};
    endfunction

    function automatic logic [OW-1:0] frac_slice(logic [AW-1:0] a, logic r);
        logic [AW-1:0] t;
        t = a + (r ? BIAS : '0);
        return t[FRAC_LSB +: OW];
    endfunction

    AST_LOAD_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 4'd5 && !$past(acc_i, 4)) |-> acc_w == widen($past(sum_w))); // R4

    AST_ADD_TOTAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 4'd5 && $past(acc_i, 4)) |-> acc_w == $past(acc_w) + widen($past(sum_w))); // R4

    AST_HOLD_OUTPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 4'd6 && !$past(out_upd_i, 5)) |-> $stable(out_w)); // R8

    AST_INT_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 4'd6 && $past(out_upd_i, 5) && !$past(frac_i, 5)) |-> out_w == $past(acc_w[OW-1:0])); // R3

    AST_FRAC_SLICE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst_q >= 4'd6 && $past(out_upd_i, 5) && $past(frac_i, 5))
            |-> out_w == frac_slice($past(acc_w), $past(rnd_i, 5))); // R7

    AST_PIN_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !oe_ni |-> res_o == out_w); // R9

endmodule

bind mac4_filter mac4_filter_chk #(.SW(SW), .AW(AW), .OW(OW), .FRAC_LSB(FRAC_LSB)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .acc_i     (acc_i),
    .frac_i    (frac_i),
    .rnd_i     (rnd_i),
    .out_upd_i (out_upd_i),
    .oe_ni     (oe_ni),
    .res_o     (res_o),
    .sum_w     (sum_w),
    .acc_w     (acc_w),
    .out_w     (out_w)
);

// File: tb/mac4_filter_tb_top.sv
module mac4_filter_tb_top;

    localparam int LANES = 4;
    localparam int DW    = 10;
    localparam int CW    = 11;
    localparam int OW    = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                     rst_n;
    logic [LANES-1:0][DW-1:0] smp;
    logic [LANES-1:0][CW-1:0] cof;
    logic [LANES-1:0]         smp_en, cof_en;
    logic                     acc, frac, rnd, upd, oe_n;
    wire  [OW-1:0]            res;

    mac4_filter dut_i (
        .clk_i(clk), .rst_ni(rst_n), .smp_i(smp), .cof_i(cof),
        .smp_en_i(smp_en), .cof_en_i(cof_en), .acc_i(acc), .frac_i(frac),
        .rnd_i(rnd), .out_upd_i(upd), .oe_ni(oe_n), .res_o(res)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string cur_req;

    // Behavioural reference: held operands, running total, output word, 5-edge delay queue.
    int                 hs[LANES];
    int                 hc[LANES];
    logic signed [24:0] m_tot;
    logic [15:0]        m_word;
    logic [15:0]        delay_q[$];

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: res_o=%h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_push();
        int sum;
        logic [24:0] t;
        sum = 0;
        for (int k = 0; k < LANES; k++) begin
            if (smp_en[k]) hs[k] = $signed(smp[k]);
            if (cof_en[k]) hc[k] = $signed(cof[k]);
            sum += hs[k] * hc[k];
        end
        m_tot = acc ? (m_tot + 25'(sum)) : 25'(sum);
        if (upd) begin
            t = m_tot + (rnd ? 25'd32 : 25'd0);
            m_word = frac ? t[21:6] : m_tot[15:0];
        end
        delay_q.push_back(m_word);
    endtask

    function automatic logic [DW-1:0] pick_smp(bit corner);
        int r;
        r = $urandom_range(0, 3);
        if (!corner) return DW'($urandom);
        case (r)
            0: return 10'h200;   // -512
            1: return 10'h1FF;   // +511
            2: return 10'h3FF;   // -1
            default: return 10'h000;
        endcase
    endfunction

    function automatic logic [CW-1:0] pick_cof(bit corner);
        if (!corner) return CW'($urandom);
        return ($urandom_range(0, 1) == 0) ? 11'h400 : 11'h3FF; // -1024 or +1023
    endfunction

    // mode: 0 plain, 1 corners, 2 accumulate runs, 3 enables, 4 fractional, 5 rounding, 6 hold mix
    task automatic drive(int mode);
        for (int k = 0; k < LANES; k++) begin
            smp[k] = pick_smp(mode == 1);
            cof[k] = pick_cof(mode == 1);
        end
        smp_en = (mode == 3 || mode == 6) ? LANES'($urandom) : '1;
        cof_en = (mode == 3 || mode == 6) ? LANES'($urandom) : '1;
        acc    = (mode == 2) ? ($urandom_range(0, 3) != 0) : (mode == 6) ? 1'($urandom) : 1'b0;
        frac   = (mode == 4) ? 1'b1 : (mode == 5 || mode == 6) ? 1'($urandom) : 1'b0;
        rnd    = (mode == 5 || mode == 6) ? 1'($urandom) : 1'b0;
        upd    = (mode == 6) ? 1'($urandom) : 1'b1;
        model_push();
    endtask

    task automatic step(int mode, bit probe_oe);
        logic [15:0] exp;
        @(negedge clk);
        exp = (delay_q.size() > 4) ? delay_q.pop_front() : 16'h0000;
        check(cur_req, res, exp);
        if (probe_oe) begin
            oe_n = 1'b1;
            #1;
            if (exp != 16'h0000) check("R9 released", (res !== exp) ? 16'h0001 : 16'h0000, 16'h0001);
            oe_n = 1'b0;
            #1;
            check("R9 restored", res, exp);
        end
        drive(mode);
    endtask

    task automatic run(string req, int mode, int cycles, bit probe_oe);
        cur_req = req;
        for (int i = 0; i < cycles; i++) step(mode, probe_oe);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < LANES; k++) begin
            hs[k] = 0;
            hc[k] = 0;
        end
        m_tot  = '0;
        m_word = '0;
        rst_n  = 1'b0;
        smp    = '0;
        cof    = '0;
        smp_en = '0;
        cof_en = '0;
        acc    = 1'b0;
        frac   = 1'b0;
        rnd    = 1'b0;
        upd    = 1'b0;
        oe_n   = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 in reset", res, 16'h0000);
        rst_n = 1'b1;
        check("R1 after release", res, 16'h0000);
        drive(0);
        run("R2 latency", 0, 40, 1'b0);
        run("R3 corner operands", 1, 40, 1'b0);
        run("R4 accumulate", 2, 40, 1'b0);
        run("R5 held registers", 3, 40, 1'b0);
        run("R6 fractional slice", 4, 30, 1'b0);
        run("R7 rounding", 5, 40, 1'b0);
        run("R8 output hold", 6, 60, 1'b1);
        run("R2 drain", 0, 6, 1'b0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule